// File: doc/BRIEF.md
# Privileged Performance Event Counter Unit

This block holds a bank of event counters for a processor core. Each clock the core presents one-cycle event strobes. These cover instruction dispatch, execution, completion and memory-access activity. Every counter picks one strobe through a 4-bit select code. A global freeze bit stops all counting. A per-counter enable lets a counter's overflow (its top bit becoming 1) raise a monitoring interrupt. When the interrupt is raised, hardware sets the freeze bit, so that software reads stable counts.

Software reaches the counters, the two control words and a sampled-address register through one read/write port. The port carries a privilege input and an alias select. Direct addresses need supervisor privilege. Alias addresses are read-only at any privilege level. A write to an alias, or a user-mode access to a direct address, raises a program-exception flag and changes nothing. After an overflow triggers the interrupt, the unit captures the address of the first instruction that completes. The interrupt is reported with a fixed vector offset.

Top module: `evmon_unit`

## Requirements
- R1: After reset, every counter, both control words and the sampled-address register read 0, and `irq_req` and `prog_exc` are low.
- R2: A supervisor (`priv_user`=0) direct (`reg_alias`=0) write updates the register at `reg_idx`. The index map is: 0..3 counters, 4 control A, 5 control B, 6 sampled address. A direct supervisor read returns that value on `reg_rdata` one cycle after the read.
- R3: An alias read (`reg_alias`=1) returns the same value as a direct read, at either privilege, and raises no exception.
- R4: Any write with `reg_alias`=1 sets `prog_exc` in the next cycle, at either privilege, and leaves the register unchanged.
- R5: Any user-mode (`priv_user`=1) access with `reg_alias`=0 sets `prog_exc` in the next cycle. Such a write changes nothing, and such a read returns 0.
- R6: Control B holds one 4-bit select per counter, with counter i at bits 4i+3:4i. Code c in 1..8 adds one per cycle in which `evt_strobe[c-1]` is high. Code 0 and codes 9..15 leave the counter unchanged.
- R7: While control A bit 0 (freeze) is 1, no counter changes except by a register write.
- R8: Control A bit i+1 enables the interrupt for counter i. When a counter with its enable set has bit 31 at 1 and freeze is 0, `irq_req` goes high and freeze is set one cycle later. With the enable clear, an overflow raises nothing.
- R9: `irq_vector` always presents offset 0x00F00.
- R10: The sampled-address register loads `cmpl_addr` from the first cycle with `cmpl_valid` at or after the cycle in which the overflow condition is first visible. Completions before it and after it do not load it.
- R11: A supervisor direct write to control A clears `irq_req` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_strobe | input | 8 | One-cycle event pulses from the core |
| cmpl_valid | input | 1 | An instruction completes this cycle |
| cmpl_addr | input | 32 | Address of the completing instruction |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_alias | input | 1 | Selects the read-only alias of the register |
| priv_user | input | 1 | 1 when the requester runs at user level |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read |
| prog_exc | output | 1 | Program exception for the access of the previous cycle |
| irq_req | output | 1 | Monitoring interrupt request |
| irq_vector | output | 20 | Interrupt vector offset |

## Verification
A wrong access decode shows at the ports one cycle after the access. It appears as a misplaced `prog_exc` pulse, or as a register whose read-back differs after a write that should have been refused. Errors in the select decode or the freeze gating show as counts that differ by the number of strobed cycles at the next read. A late or early sample arm shows as the wrong one of three distinct completion addresses in the sampled register. A missing hardware freeze shows as a count that keeps moving after `irq_req` rises.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
   localparam int IDX_W      = 3;
   localparam int IDX_CTL_A  = 4;
   localparam int IDX_CTL_B  = 5;
   localparam int IDX_SAMPLE = 6;
   localparam int FRZ_BIT    = 0;
   localparam int MAX_CNT    = 4;
endpackage

// File: rtl/evmon_access.sv
module evmon_access (
   input  logic clk,
   input  logic rst_n,
   input  logic reg_wr,
   input  logic reg_rd,
   input  logic reg_alias,
   input  logic priv_user,
   output logic wr_ok,
   output logic rd_ok,
   output logic prog_exc
);
   logic exc_d;

   always_comb begin
      exc_d = (reg_wr && reg_alias) || ((reg_wr || reg_rd) && priv_user && !reg_alias);
      wr_ok = reg_wr && !reg_alias && !priv_user;
      rd_ok = reg_rd && !exc_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prog_exc <= 1'b0;
      else        prog_exc <= exc_d;
   end

   AST_ALIAS_WR_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_alias) |=> prog_exc); // R4
   AST_USER_DIRECT_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_wr || reg_rd) && priv_user && !reg_alias) |=> prog_exc); // R5
endmodule

// File: rtl/evmon_counter.sv
module evmon_counter #(
   parameter int CNT_W = 32,
   parameter int NEVT  = 8,
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             freeze,
   input  logic [SEL_W-1:0] sel,
   input  logic [NEVT-1:0]  evt,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);
   logic hit;

   always_comb begin
      hit = 1'b0;
      for (int e = 0; e < NEVT; e++) begin
         if (sel == SEL_W'(e + 1)) hit = evt[e];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (wr_en)          cnt <= wr_data;
      else if (!freeze && hit) cnt <= cnt + 1'b1;
   end

   assign ovf = cnt[CNT_W-1];

   AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !wr_en) |=> $stable(cnt)); // R7
   AST_IDLE_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel == '0) && !wr_en) |=> $stable(cnt)); // R6
endmodule

// File: rtl/evmon_sampler.sv
module evmon_sampler #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trig,
   input  logic          cmpl_valid,
   input  logic [AW-1:0] cmpl_addr,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_data,
   output logic [AW-1:0] sample
);
   logic armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sample <= '0;
         armed  <= 1'b0;
      end else begin
         if (wr_en) sample <= wr_data;
         if (cmpl_valid && (armed || trig)) begin
            sample <= cmpl_addr;
            armed  <= 1'b0;
         end else if (trig) begin
            armed <= 1'b1;
         end
      end
   end

   AST_SAMPLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !trig && !wr_en) |=> $stable(sample)); // R10
   AST_ARM_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !cmpl_valid) |=> armed); // R10
endmodule

// File: rtl/evmon_unit.sv
module evmon_unit #(
   parameter int                 NCNT    = 4,
   parameter int                 CNT_W   = 32,
   parameter int                 DATA_W  = 32,
   parameter int                 NEVT    = 8,
   parameter int                 AW      = 32,
   parameter int                 SEL_W   = 4,
   parameter int                 VEC_W   = 20,
   parameter logic [VEC_W-1:0]   VEC_OFS = 20'h00F00
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NEVT-1:0]                   evt_strobe,
   input  logic                              cmpl_valid,
   input  logic [AW-1:0]                     cmpl_addr,
   input  logic                              reg_wr,
   input  logic                              reg_rd,
   input  logic                              reg_alias,
   input  logic                              priv_user,
   input  logic [evmon_pkg::IDX_W-1:0]       reg_idx,
   input  logic [DATA_W-1:0]                 reg_wdata,
   output logic [DATA_W-1:0]                 reg_rdata,
   output logic                              prog_exc,
   output logic                              irq_req,
   output logic [VEC_W-1:0]                  irq_vector
);
   import evmon_pkg::*;

   localparam int SEL_SPAN = NCNT * SEL_W;

   if (NCNT < 1 || NCNT > MAX_CNT) begin : g_bad_ncnt
      $error("NCNT must be 1..4");
   end
   if (CNT_W > DATA_W || AW > DATA_W) begin : g_bad_width
      $error("counter and address widths must fit the data word");
   end
   if (SEL_SPAN > DATA_W || NCNT + 1 > DATA_W) begin : g_bad_ctl
      $error("control fields must fit the data word");
   end
   if (NEVT >= (1 << SEL_W)) begin : g_bad_nevt
      $error("event count must be below the select code range");
   end

   logic                wr_ok, rd_ok, trig;
   logic [DATA_W-1:0]   ctrl_a_q, ctrl_b_q, rd_mux;
   logic [CNT_W-1:0]    cnt_arr [NCNT];
   logic [NCNT-1:0]     ovf_vec;
   logic [AW-1:0]       sample;
   logic                ctl_a_we, ctl_b_we, smp_we;

   evmon_access u_access (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_alias (reg_alias),
      .priv_user (priv_user),
      .wr_ok     (wr_ok),
      .rd_ok     (rd_ok),
      .prog_exc  (prog_exc)
   );

   assign ctl_a_we = wr_ok && (reg_idx == IDX_W'(IDX_CTL_A));
   assign ctl_b_we = wr_ok && (reg_idx == IDX_W'(IDX_CTL_B));
   assign smp_we   = wr_ok && (reg_idx == IDX_W'(IDX_SAMPLE));

   for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      evmon_counter #(
         .CNT_W (CNT_W),
         .NEVT  (NEVT),
         .SEL_W (SEL_W)
      ) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .freeze  (ctrl_a_q[FRZ_BIT]),
         .sel     (ctrl_b_q[i*SEL_W +: SEL_W]),
         .evt     (evt_strobe),
         .wr_en   (wr_ok && (reg_idx == IDX_W'(i))),
         .wr_data (reg_wdata[CNT_W-1:0]),
         .cnt     (cnt_arr[i]),
         .ovf     (ovf_vec[i])
      );
   end

   assign trig = !ctrl_a_q[FRZ_BIT] && |(ovf_vec & ctrl_a_q[NCNT:1]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_a_q <= '0;
         ctrl_b_q <= '0;
         irq_req  <= 1'b0;
      end else begin
         if (ctl_a_we) ctrl_a_q <= reg_wdata;
         if (trig)     ctrl_a_q[FRZ_BIT] <= 1'b1;
         if (ctl_b_we) ctrl_b_q <= reg_wdata;
         if (ctl_a_we) irq_req <= 1'b0;
         if (trig)     irq_req <= 1'b1;
      end
   end

   evmon_sampler #(.AW(AW)) u_sampler (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig       (trig),
      .cmpl_valid (cmpl_valid),
      .cmpl_addr  (cmpl_addr),
      .wr_en      (smp_we),
      .wr_data    (reg_wdata[AW-1:0]),
      .sample     (sample)
   );

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NCNT; i++) begin
         if (reg_idx == IDX_W'(i)) rd_mux = DATA_W'(cnt_arr[i]);
      end
      if (reg_idx == IDX_W'(IDX_CTL_A))  rd_mux = ctrl_a_q;
      if (reg_idx == IDX_W'(IDX_CTL_B))  rd_mux = ctrl_b_q;
      if (reg_idx == IDX_W'(IDX_SAMPLE)) rd_mux = DATA_W'(sample);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     reg_rdata <= '0;
      else if (rd_ok) reg_rdata <= rd_mux;
      else            reg_rdata <= '0;
   end

   assign irq_vector = VEC_OFS;

   AST_IRQ_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> ctrl_a_q[FRZ_BIT]); // R8
   AST_USER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_user && reg_wr && !trig) |=> ($stable(ctrl_a_q) && $stable(ctrl_b_q))); // R5
   AST_CLEAR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_a_we && !trig) |=> !irq_req); // R11
endmodule

// File: tb/test_evmon_unit.sv
module test_evmon_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  evt_strobe = '0;
   logic        cmpl_valid = 1'b0;
   logic [31:0] cmpl_addr = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_alias = 1'b0, priv_user = 1'b0;
   logic [2:0]  reg_idx = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        prog_exc, irq_req;
   logic [19:0] irq_vector;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [31:0] data;
      bit          chk_data;
      bit          exc;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   always #5 clk = ~clk;

   evmon_unit i_evmon_unit (
      .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .cmpl_valid(cmpl_valid),
      .cmpl_addr(cmpl_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_alias(reg_alias),
      .priv_user(priv_user), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .prog_exc(prog_exc), .irq_req(irq_req),
      .irq_vector(irq_vector)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: one access, expected response queued for the monitor
   task automatic acc(input bit wr, input int idx, input bit als, input bit usr,
                      input logic [31:0] wd, input logic [31:0] exp_d,
                      input bit chk_d, input bit exp_exc, input string tag);
      exp_t it;
      @(negedge clk);
      reg_wr = wr; reg_rd = !wr; reg_idx = 3'(idx);
      reg_alias = als; priv_user = usr; reg_wdata = wd;
      it.data = exp_d; it.chk_data = chk_d; it.exc = exp_exc; it.tag = tag;
      exp_q.push_back(it);
      @(negedge clk);
      reg_wr = 1'b0; reg_rd = 1'b0; reg_alias = 1'b0; priv_user = 1'b0;
   endtask

   // monitor: compares the registered response just after each access edge
   always @(posedge clk) begin
      #1;
      if (reg_wr || reg_rd) begin
         exp_t it;
         if (exp_q.size() == 0) begin
            check(1'b0, "scoreboard underflow", 32'd0, 32'd1);
         end else begin
            it = exp_q.pop_front();
            check(prog_exc == it.exc, {it.tag, " exc"}, 32'(prog_exc), 32'(it.exc));
            if (it.chk_data)
               check(reg_rdata == it.data, {it.tag, " data"}, reg_rdata, it.data);
         end
      end
   end

   task automatic pulse(input logic [7:0] ev, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); evt_strobe = ev;
      end
      @(negedge clk); evt_strobe = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(irq_req == 1'b0, "R1 irq after reset", 32'(irq_req), 32'd0);
      check(prog_exc == 1'b0, "R1 exc after reset", 32'(prog_exc), 32'd0);
      check(irq_vector == 20'h00F00, "R9 vector", 32'(irq_vector), 32'h00F00);
      acc(0, 0, 0, 0, 0, 32'h0, 1, 0, "R1 cnt0 reset");
      acc(0, 6, 1, 1, 0, 32'h0, 1, 0, "R1 sample reset");
      acc(0, 4, 0, 0, 0, 32'h0, 1, 0, "R1 ctrlA reset");

      acc(1, 1, 0, 0, 32'h1234_5678, 0, 0, 0, "R2 write cnt1");
      acc(0, 1, 0, 0, 0, 32'h1234_5678, 1, 0, "R2 read cnt1");
      acc(0, 1, 1, 1, 0, 32'h1234_5678, 1, 0, "R3 user alias read");
      acc(0, 1, 1, 0, 0, 32'h1234_5678, 1, 0, "R3 super alias read");

      acc(1, 1, 1, 0, 32'h0000_DEAD, 0, 0, 1, "R4 super alias write");
      acc(1, 1, 1, 1, 32'h0000_BEEF, 0, 0, 1, "R4 user alias write");
      acc(0, 1, 0, 0, 0, 32'h1234_5678, 1, 0, "R4 unchanged");

      acc(1, 1, 0, 1, 32'h0, 0, 0, 1, "R5 user direct write");
      acc(0, 1, 0, 1, 0, 32'h0, 1, 1, "R5 user direct read");
      acc(0, 1, 0, 0, 0, 32'h1234_5678, 1, 0, "R5 unchanged");

      // selects: c0=code3 (evt2), c1=code0, c2=code9, c3=code8 (evt7)
      acc(1, 5, 0, 0, 32'h0000_8903, 0, 0, 0, "R6 write ctrlB");
      acc(0, 5, 0, 0, 0, 32'h0000_8903, 1, 0, "R2 read ctrlB");
      pulse(8'hFF, 5);
      pulse(8'h04, 2);
      acc(0, 0, 0, 0, 0, 32'd7, 1, 0, "R6 cnt0 code3");
      acc(0, 1, 0, 0, 0, 32'h1234_5678, 1, 0, "R6 cnt1 code0 holds");
      acc(0, 2, 0, 0, 0, 32'd0, 1, 0, "R6 cnt2 code9 holds");
      acc(0, 3, 0, 0, 0, 32'd5, 1, 0, "R6 cnt3 code8");

      acc(1, 4, 0, 0, 32'h1, 0, 0, 0, "R7 set freeze");
      pulse(8'hFF, 3);
      acc(0, 0, 0, 0, 0, 32'd7, 1, 0, "R7 cnt0 frozen");
      acc(0, 3, 0, 0, 0, 32'd5, 1, 0, "R7 cnt3 frozen");

      // overflow without enable
      acc(1, 4, 0, 0, 32'h0, 0, 0, 0, "R8 unfreeze");
      acc(1, 3, 0, 0, 32'h7FFF_FFFF, 0, 0, 0, "R8 preset cnt3");
      pulse(8'h80, 1);
      repeat (3) @(negedge clk);
      check(irq_req == 1'b0, "R8 no irq without enable", 32'(irq_req), 32'd0);
      acc(0, 3, 0, 0, 0, 32'h8000_0000, 1, 0, "R6 cnt3 reaches msb");
      acc(1, 3, 0, 0, 32'h0, 0, 0, 0, "R8 clear cnt3");

      // overflow with enable on counter 0, and sampling
      acc(1, 0, 0, 0, 32'h7FFF_FFFF, 0, 0, 0, "R8 preset cnt0");
      acc(1, 4, 0, 0, 32'h2, 0, 0, 0, "R8 enable cnt0");
      @(negedge clk);
      evt_strobe = 8'h04; cmpl_valid = 1'b1; cmpl_addr = 32'h100;
      @(negedge clk);
      evt_strobe = '0; cmpl_valid = 1'b0;
      check(irq_req == 1'b0, "R8 irq not yet", 32'(irq_req), 32'd0);
      @(negedge clk);
      check(irq_req == 1'b1, "R8 irq raised", 32'(irq_req), 32'd1);
      cmpl_valid = 1'b1; cmpl_addr = 32'h200;
      @(negedge clk);
      cmpl_addr = 32'h300;
      @(negedge clk);
      cmpl_valid = 1'b0;
      acc(0, 6, 1, 1, 0, 32'h200, 1, 0, "R10 first completion sampled");
      acc(0, 4, 0, 0, 0, 32'h3, 1, 0, "R8 freeze set by hardware");
      pulse(8'h04, 2);
      acc(0, 0, 0, 0, 0, 32'h8000_0000, 1, 0, "R7 counts stable after irq");

      acc(1, 6, 1, 1, 32'hFFFF_0000, 0, 0, 1, "R4 alias write sample");
      acc(0, 6, 0, 0, 0, 32'h200, 1, 0, "R4 sample unchanged");

      acc(1, 4, 0, 0, 32'h0, 0, 0, 0, "R11 clear ctrlA");
      check(irq_req == 1'b0, "R11 irq cleared", 32'(irq_req), 32'd0);
      repeat (2) @(negedge clk);
      check(irq_vector == 20'h00F00, "R9 vector stable", 32'(irq_vector), 32'h00F00);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule